// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This master-side block frees a two-wire bus when a slave has been left partway through a transfer. That can happen after a protocol interruption, a power loss or a system reset, and it leaves the slave holding the data line low. On request, the block clocks the bus with open-drain pulses while it keeps its own data driver released. At the end of every clock-high phase it samples the data line. As soon as the line reads high, it stops clocking. It then places a start condition and, right after it, a stop condition, so the bus is left idle.

The length of the clock low phase and the length of the clock high phase are each given in system clocks. Both are captured when a request is accepted. The block never issues more than nine pulses. If the data line is still low at the end of the ninth high phase, it reports a failure instead of completion. Both line outputs are open-drain enables: a 1 pulls the line low, and a 0 releases it.

Top module: `bus_recover_seq`

## Requirements
- R1: While reset is asserted and in the cycle after it, `scl_oe_o`, `sda_oe_o`, `busy_o`, `done_o` and `fail_o` are all 0.
- R2: A request is accepted only in the idle state. `busy_o` is 1 from the cycle after acceptance until the cycle in which `done_o` or `fail_o` is 1, and `busy_o` is 0 in that cycle. A request made while busy has no effect.
- R3: Each pulse holds `scl_oe_o` at 1 for `lo_len_i` cycles and then at 0 for `hi_len_i` cycles. Both lengths are captured at acceptance, and a length of 0 acts as 1. Changing the length inputs while busy does not change the timing.
- R4: `sda_oe_o` stays 0 for the whole clocking phase.
- R5: The data line is sampled in the last cycle of each high phase. If it is high, no further pulse follows, and `sda_oe_o` is then 1 for `hi_len_i` cycles while `scl_oe_o` stays 0. This is the start condition.
- R6: After the start condition, `sda_oe_o` returns to 0 with `scl_oe_o` still 0 for `hi_len_i` cycles. This is the stop condition. Then `done_o` is 1 for one cycle, with both enables at 0.
- R7: At most nine pulses are issued. If the data line is low at the end of the ninth high phase, `fail_o` is 1 for one cycle and both enables are 0.
- R8: `done_o` and `fail_o` are never 1 together, and each lasts one cycle.
- R9: `scl_oe_o` and `sda_oe_o` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Start a recovery (taken only when idle) |
| lo_len_i | input | CNT_W | Clock low phase length in system clocks |
| hi_len_i | input | CNT_W | Clock high phase length in system clocks |
| sda_i | input | 1 | Sensed level of the data line |
| scl_oe_o | output | 1 | 1 pulls the clock line low |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| busy_o | output | 1 | Recovery in progress |
| done_o | output | 1 | One-cycle pulse: bus recovered |
| fail_o | output | 1 | One-cycle pulse: data line still low after nine pulses |

## Verification
The hardest case to reach is the exact boundary at the ninth pulse. Releasing the data line during the ninth high phase must give completion, while releasing it one pulse later must give failure. The bench models a slave that holds the data line low until it has seen a chosen number of pulses, and it runs the release count at 0, 1, 4, 9 and 20. A behavioural model tracks every cycle. One run changes the phase lengths and raises a second request mid-recovery, to show that both are ignored.

// File: rtl/bus_recover_pkg.sv
package bus_recover_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOW   = 3'd1,
    ST_HIGH  = 3'd2,
    ST_START = 3'd3,
    ST_STOP  = 3'd4
  } rec_state_t;
endpackage

// File: rtl/bus_recover_timer.sv
module bus_recover_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= load_val;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/bus_recover_pcount.sv
module bus_recover_pcount #(
  parameter int MAX_PULSES = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic inc,
  output logic last
);
  localparam int PW = $clog2(MAX_PULSES + 1);
  localparam logic [PW-1:0] LAST_VAL = PW'(MAX_PULSES - 1);

  logic [PW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear)
      cnt <= '0;
    else if (inc)
      cnt <= cnt + 1'b1;
  end

  assign last = (cnt == LAST_VAL);
endmodule

// File: rtl/bus_recover_seq.sv
module bus_recover_seq
  import bus_recover_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int MAX_PULSES = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_i,
  input  logic [CNT_W-1:0] lo_len_i,
  input  logic [CNT_W-1:0] hi_len_i,
  input  logic             sda_i,
  output logic             scl_oe_o,
  output logic             sda_oe_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             fail_o
);
  rec_state_t       state, nxt;
  logic [CNT_W-1:0] lo_q, hi_q;
  logic [CNT_W-1:0] lo_in_m1, hi_in_m1;
  logic             t_load, t_exp;
  logic [CNT_W-1:0] t_val;
  logic             p_clr, p_inc, p_last;
  logic             set_done, set_fail;

  // Phase lengths are stored minus one; zero behaves as one.
  assign lo_in_m1 = (lo_len_i == '0) ? '0 : lo_len_i - 1'b1;
  assign hi_in_m1 = (hi_len_i == '0) ? '0 : hi_len_i - 1'b1;

  bus_recover_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .expired(t_exp)
  );

  bus_recover_pcount #(.MAX_PULSES(MAX_PULSES)) u_pcount (
    .clk(clk), .rst(rst), .clear(p_clr), .inc(p_inc), .last(p_last)
  );

  always_comb begin
    nxt      = state;
    t_load   = 1'b0;
    t_val    = hi_q;
    p_clr    = 1'b0;
    p_inc    = 1'b0;
    set_done = 1'b0;
    set_fail = 1'b0;
    unique case (state)
      ST_IDLE: if (req_i) begin
        nxt    = ST_LOW;
        t_load = 1'b1;
        t_val  = lo_in_m1;
        p_clr  = 1'b1;
      end
      ST_LOW: if (t_exp) begin
        nxt    = ST_HIGH;
        t_load = 1'b1;
      end
      ST_HIGH: if (t_exp) begin
        if (sda_i) begin
          nxt    = ST_START;
          t_load = 1'b1;
        end else if (p_last) begin
          nxt      = ST_IDLE;
          set_fail = 1'b1;
        end else begin
          nxt    = ST_LOW;
          t_load = 1'b1;
          t_val  = lo_q;
          p_inc  = 1'b1;
        end
      end
      ST_START: if (t_exp) begin
        nxt    = ST_STOP;
        t_load = 1'b1;
      end
      ST_STOP: if (t_exp) begin
        nxt      = ST_IDLE;
        set_done = 1'b1;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      lo_q     <= '0;
      hi_q     <= '0;
      scl_oe_o <= 1'b0;
      sda_oe_o <= 1'b0;
      busy_o   <= 1'b0;
      done_o   <= 1'b0;
      fail_o   <= 1'b0;
    end else begin
      state <= nxt;
      if (state == ST_IDLE && req_i) begin
        lo_q <= lo_in_m1;
        hi_q <= hi_in_m1;
      end
      scl_oe_o <= (nxt == ST_LOW);
      sda_oe_o <= (nxt == ST_START);
      busy_o   <= (nxt != ST_IDLE);
      done_o   <= set_done;
      fail_o   <= set_fail;
    end
  end
endmodule

// File: rtl/bus_recover_chk.sv
module bus_recover_chk #(
  parameter int MAX_PULSES = 9
) (
  input logic clk,
  input logic rst,
  input logic req_i,
  input logic scl_oe_o,
  input logic sda_oe_o,
  input logic busy_o,
  input logic done_o,
  input logic fail_o
);
  int unsigned pulses;
  logic        scl_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      pulses <= 0;
      scl_d  <= 1'b0;
    end else begin
      scl_d <= scl_oe_o;
      if (!busy_o)
        pulses <= 0;
      else if (scl_oe_o && !scl_d)
        pulses <= pulses + 1;
    end
  end

  assert_lines_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    !(scl_oe_o && sda_oe_o));

  assert_status_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    !(done_o && fail_o));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_busy_rise_after_req_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(req_i));

  assert_busy_fall_with_status_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> (done_o || fail_o));

  assert_start_scl_high_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe_o) |-> (!scl_oe_o && !$past(scl_oe_o)));

  assert_stop_scl_high_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(sda_oe_o) |-> !scl_oe_o);

  assert_done_released_R6: assert property (@(posedge clk) disable iff (rst)
    (done_o || fail_o) |-> (!scl_oe_o && !sda_oe_o && !busy_o));

  assert_pulse_limit_R7: assert property (@(posedge clk) disable iff (rst)
    pulses <= MAX_PULSES);
endmodule

bind bus_recover_seq bus_recover_chk #(.MAX_PULSES(MAX_PULSES)) u_chk (
  .clk(clk), .rst(rst), .req_i(req_i), .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o),
  .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o)
);

// File: tb/bus_recover_seq_bench.sv
`timescale 1ns/1ps
module bus_recover_seq_bench;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             req = 1'b0;
  logic [CNT_W-1:0] lo_len = '0;
  logic [CNT_W-1:0] hi_len = '0;
  logic             scl_oe, sda_oe, busy, done, fail;
  logic             sda_line;

  int checks = 0;
  int bad    = 0;
  int cycles = 0;

  // slave model: holds data low until it has seen hold_n pulses
  int   hold_n = 0;
  int   seen   = 0;
  logic scl_prev = 1'b0;
  logic sda_smp  = 1'b1;

  always #4 clk = ~clk;

  assign sda_line = !(sda_oe || (seen < hold_n));

  bus_recover_seq #(.CNT_W(CNT_W)) u_bus_recover_seq (
    .clk(clk), .rst(rst), .req_i(req), .lo_len_i(lo_len), .hi_len_i(hi_len),
    .sda_i(sda_line), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .busy_o(busy),
    .done_o(done), .fail_o(fail)
  );

  always @(negedge clk) begin
    if (scl_oe && !scl_prev) seen = seen + 1;
    scl_prev = scl_oe;
    sda_smp  = !(sda_oe || (seen < hold_n));
  end

  // reference model
  int m_ph, m_el, m_n, m_lo, m_hi;
  bit m_done, m_fail;

  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_el = 0; m_n = 0; m_lo = 1; m_hi = 1; m_done = 0; m_fail = 0;
    end else begin
      m_done = 0; m_fail = 0;
      case (m_ph)
        0: if (req) begin
             m_lo = (lo_len == 0) ? 1 : int'(lo_len);
             m_hi = (hi_len == 0) ? 1 : int'(hi_len);
             m_ph = 1; m_el = 0; m_n = 0;
           end
        1: begin m_el++; if (m_el == m_lo) begin m_ph = 2; m_el = 0; end end
        2: begin
             m_el++;
             if (m_el == m_hi) begin
               m_el = 0;
               if (sda_smp) m_ph = 3;
               else begin
                 m_n++;
                 if (m_n == 9) begin m_ph = 0; m_fail = 1; end
                 else m_ph = 1;
               end
             end
           end
        3: begin m_el++; if (m_el == m_hi) begin m_ph = 4; m_el = 0; end end
        default: begin
             m_el++;
             if (m_el == m_hi) begin m_ph = 0; m_el = 0; m_done = 1; end
           end
      endcase
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk("R3 scl_oe", scl_oe, m_ph == 1);
      chk("R4 R5 sda_oe", sda_oe, m_ph == 3);
      chk("R2 busy", busy, m_ph != 0);
      chk("R6 done", done, m_done);
      chk("R7 fail", fail, m_fail);
      chk("R8 done and fail together", done && fail, 0);
      chk("R9 both lines pulled", scl_oe && sda_oe, 0);
    end
  end

  task automatic run(input int lo, input int hi, input int n, input bit want_done,
                     input int want_pulses, input bit poke);
    bit got_d = 0, got_f = 0;
    hold_n = n;
    seen   = 0;
    @(negedge clk);
    req = 1'b1; lo_len = CNT_W'(lo); hi_len = CNT_W'(hi);
    @(negedge clk);
    req = 1'b0;
    for (int i = 0; i < 4000 && !got_d && !got_f; i++) begin
      if (poke && i == 3) begin req = 1'b1; lo_len = 16'd7; hi_len = 16'd9; end
      else req = 1'b0;
      @(negedge clk);
      got_d = done; got_f = fail;
    end
    req = 1'b0;
    chk("R6 R7 outcome done", got_d, want_done);
    chk("R6 R7 outcome fail", got_f, !want_done);
    chk("R5 R7 pulse count", seen, want_pulses);
    @(negedge clk);
    chk("R6 lines released after end", scl_oe || sda_oe || busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {scl_oe, sda_oe, busy, done, fail}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 outputs after reset", {scl_oe, sda_oe, busy, done, fail}, 0);
    run(3, 2, 0, 1'b1, 1, 1'b0);   // R5 released at once
    run(2, 4, 4, 1'b1, 4, 1'b0);   // R5 release on fourth pulse
    run(1, 1, 9, 1'b1, 9, 1'b0);   // R7 release on ninth pulse
    run(2, 3, 20, 1'b0, 9, 1'b0);  // R7 stuck line -> fail
    run(0, 0, 2, 1'b1, 2, 1'b0);   // R3 zero lengths act as one
    run(3, 2, 3, 1'b1, 3, 1'b1);   // R2 R3 request and length change while busy
    run(5, 1, 1, 1'b1, 1, 1'b0);
    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    bad++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=<150000 cycles", cycles);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule